// File: doc/BRIEF.md
# Single-Operand ALU (Increment and Rotate-Right-Through-Carry)

This block runs the two single-operand instructions of an 8-bit controller: add one to a register, and rotate a register right through the carry flag. It receives an instruction word together with the current status byte. It decodes the destination register index from the word and drives that index out on a register-file read address. The operand comes back on the read-data pin in the same cycle. One cycle later the block presents the write-back value, the index, a write strobe and the updated status byte.

Instructions enter on a valid/ready stream, and results leave on a second valid/ready stream. Each accepted instruction produces exactly one output beat. That beat is registered and appears in the cycle after acceptance. Back-pressure works as follows:
- While `res_ready` is low, a pending beat keeps every output field frozen.
- `cmd_ready` is high whenever the output stage is empty or is being drained in the same cycle.
- An unrecognised word still produces a beat. That beat carries no write strobe and the status byte unchanged, so the stream order is preserved.

Top module: `sop_alu`

## Requirements
- R1: A word with (word & 0xFE0F) == 0x9403 is an increment. Its register index is word bits [8:4]. That index appears on `rf_addr` while the command is offered and on `res_idx` with its result.
- R2: A word with (word & 0xFE0F) == 0x9407 is a rotate-right and uses the same index field.
- R3: Increment writes (operand + 1) mod 256. Z (bit 1) is set iff the result is zero, and N (bit 2) equals result bit 7. V (bit 3) is set only when the operand was 0x7F.
- R4: Increment leaves C (bit 0) at its incoming value.
- R5: Rotate writes the operand shifted right by one with the incoming C in bit 7. The new C is operand bit 0.
- R6: For rotate, Z is set iff the result is zero, N is result bit 7, and V = N xor C, computed on the new values.
- R7: For both instructions, S (bit 4) = N xor V.
- R8: Status bits 5, 6 and 7 pass through unchanged for every word.
- R9: Any other word yields a beat with `res_we` low, `res_data` zero and `res_sreg` equal to the incoming status byte.
- R10: An accepted command yields its result beat in the next cycle. `cmd_ready` = !res_valid || res_ready. A beat held by low `res_ready` keeps all fields stable.
- R11: After reset `res_valid` is low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Instruction offered |
| cmd_ready | output | 1 | Instruction accepted this cycle when valid |
| cmd_word | input | 16 | Instruction word |
| cmd_sreg | input | 8 | Current status byte |
| rf_addr | output | 5 | Register-file read address |
| rf_data | input | 8 | Register-file read data for `rf_addr` |
| res_valid | output | 1 | Result beat present |
| res_ready | input | 1 | Consumer takes the beat |
| res_we | output | 1 | Write-back strobe |
| res_idx | output | 5 | Destination register index |
| res_data | output | 8 | Write-back value |
| res_sreg | output | 8 | Updated status byte |

## Verification
The increment is tried on the operands 0x7F, 0xFF, 0x00 and an ordinary value. Together these separate the overflow rule from the zero and sign rules, and they show that the wrap to zero does not disturb C. The rotate is tried on 0x11 with C clear and with C set, and on 0x01 with C clear. These show carry entering bit 7, operand bit 0 becoming C, V taken as N xor C, and the zero result. Near-miss words that differ from a legal pattern in the low nibble or in the fixed high bits show that decoding rejects them. High status bits are varied to show that they pass through. Periods of withheld `res_ready` show the beats stay frozen and in order.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int          OPC_W    = 16;
  localparam logic [15:0] OPC_MASK = 16'hFE0F;
  localparam logic [15:0] OPC_INC  = 16'h9403;
  localparam logic [15:0] OPC_ROR  = 16'h9407;
  localparam int          IDX_LSB  = 4;

  localparam int SR_W = 8;
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_INC  = 2'd1,
    K_ROR  = 2'd2
  } op_kind_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
    logic s;
  } arith_flags_t;
endpackage

// File: rtl/sop_decode.sv
module sop_decode
  import sop_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [OPC_W-1:0] word,
  output op_kind_e         kind,
  output logic [IDX_W-1:0] idx
);
  logic [OPC_W-1:0] masked;

  always_comb begin
    masked = word & OPC_MASK;
    if (masked == OPC_INC)      kind = K_INC;
    else if (masked == OPC_ROR) kind = K_ROR;
    else                        kind = K_NONE;
    idx = word[IDX_LSB +: IDX_W];
  end
endmodule

// File: rtl/sop_inc.sv
module sop_inc
  import sop_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]  opnd,
  input  logic          c_in,
  output logic [W-1:0]  result,
  output arith_flags_t  fl
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    result = opnd + W'(1);
    fl.c   = c_in;
    fl.z   = (result == '0);
    fl.n   = result[W-1];
    fl.v   = (opnd == MAX_POS);
    fl.s   = fl.n ^ fl.v;
  end
endmodule

// File: rtl/sop_ror.sv
module sop_ror
  import sop_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]  opnd,
  input  logic          c_in,
  output logic [W-1:0]  result,
  output arith_flags_t  fl
);
  always_comb begin
    result = {c_in, opnd[W-1:1]};
    fl.c   = opnd[0];
    fl.z   = (result == '0);
    fl.n   = result[W-1];
    fl.v   = fl.n ^ fl.c;
    fl.s   = fl.n ^ fl.v;
  end
endmodule

// File: rtl/sop_alu.sv
module sop_alu
  import sop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [15:0]       cmd_word,
  input  logic [7:0]        cmd_sreg,
  output logic [IDX_W-1:0]  rf_addr,
  input  logic [DATA_W-1:0] rf_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_we,
  output logic [IDX_W-1:0]  res_idx,
  output logic [DATA_W-1:0] res_data,
  output logic [7:0]        res_sreg
);
  op_kind_e          kind;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] inc_res, ror_res, nxt_data;
  arith_flags_t      inc_fl, ror_fl, sel_fl;
  logic [SR_W-1:0]   nxt_sreg;
  logic              nxt_we, accept;

  sop_decode #(.IDX_W(IDX_W)) u_dec (
    .word(cmd_word), .kind(kind), .idx(idx)
  );

  sop_inc #(.W(DATA_W)) u_inc (
    .opnd(rf_data), .c_in(cmd_sreg[FL_C]), .result(inc_res), .fl(inc_fl)
  );

  sop_ror #(.W(DATA_W)) u_ror (
    .opnd(rf_data), .c_in(cmd_sreg[FL_C]), .result(ror_res), .fl(ror_fl)
  );

  assign rf_addr   = idx;
  assign cmd_ready = !res_valid || res_ready;
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    nxt_sreg = cmd_sreg;
    nxt_data = '0;
    nxt_we   = 1'b0;
    sel_fl   = inc_fl;
    unique case (kind)
      K_INC: begin
        nxt_data = inc_res;
        nxt_we   = 1'b1;
        sel_fl   = inc_fl;
      end
      K_ROR: begin
        nxt_data = ror_res;
        nxt_we   = 1'b1;
        sel_fl   = ror_fl;
      end
      default: ;
    endcase
    if (nxt_we) begin
      nxt_sreg[FL_C] = sel_fl.c;
      nxt_sreg[FL_Z] = sel_fl.z;
      nxt_sreg[FL_N] = sel_fl.n;
      nxt_sreg[FL_V] = sel_fl.v;
      nxt_sreg[FL_S] = sel_fl.s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_we    <= 1'b0;
      res_idx   <= '0;
      res_data  <= '0;
      res_sreg  <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_we    <= nxt_we;
      res_idx   <= idx;
      res_data  <= nxt_data;
      res_sreg  <= nxt_sreg;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  AST_INC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    accept && kind == K_INC |=> res_sreg[FL_C] == $past(cmd_sreg[FL_C])); // R4
  AST_ROR_C_FROM_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    accept && kind == K_ROR |=> res_sreg[FL_C] == $past(rf_data[0])); // R5
  AST_SIGN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_we |-> res_sreg[FL_S] == (res_sreg[FL_N] ^ res_sreg[FL_V])); // R7
  AST_HIGH_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_sreg[7:5] == $past(cmd_sreg[7:5])); // R8
  AST_ILLEGAL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && kind == K_NONE |=> !res_we && res_sreg == $past(cmd_sreg)); // R9
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_sreg)
                                && $stable(res_idx) && $stable(res_we)); // R10
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid); // R10
endmodule

// File: tb/sop_alu_test.sv
module sop_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_word = '0;
  logic [7:0]  cmd_sreg = '0;
  logic [4:0]  rf_addr;
  logic [7:0]  rf_data;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_we;
  logic [4:0]  res_idx;
  logic [7:0]  res_data;
  logic [7:0]  res_sreg;

  logic [7:0] regs [32];
  assign rf_data = regs[rf_addr];

  always #4 clk = ~clk;

  sop_alu uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .cmd_sreg(cmd_sreg), .rf_addr(rf_addr), .rf_data(rf_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_we(res_we), .res_idx(res_idx),
    .res_data(res_data), .res_sreg(res_sreg)
  );

  typedef struct packed {
    logic       we;
    logic [4:0] idx;
    logic [7:0] data;
    logic [7:0] sreg;
  } beat_t;

  beat_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit bp_on = 1'b0;
  bit done  = 1'b0;

  function automatic beat_t model(input logic [15:0] w, input logic [7:0] d, input logic [7:0] s);
    beat_t b;
    logic [7:0] r;
    logic c, z, n, v;
    b.idx = w[8:4];
    b.sreg = s;
    b.we = 1'b0;
    b.data = 8'h00;
    if ((w & 16'hFE0F) == 16'h9403) begin
      r = d + 8'd1; c = s[0]; z = (r == 0); n = r[7]; v = (d == 8'h7F);
      b.we = 1'b1; b.data = r; b.sreg[4:0] = {n ^ v, v, n, z, c};
    end else if ((w & 16'hFE0F) == 16'h9407) begin
      r = {s[0], d[7:1]}; c = d[0]; z = (r == 0); n = r[7]; v = n ^ c;
      b.we = 1'b1; b.data = r; b.sreg[4:0] = {n ^ v, v, n, z, c};
    end
    return b;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w, input logic [7:0] d, input logic [7:0] s);
    beat_t e;
    regs[w[8:4]] = d;
    cmd_word = w;
    cmd_sreg = s;
    cmd_valid = 1'b1;
    e = model(w, d, s);
    forever begin
      #1;
      if (cmd_ready) begin
        check(rf_addr == w[8:4], "R1", "rf_addr", 32'(rf_addr), 32'(w[8:4]));
        exp_q.push_back(e);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle();
    cmd_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin
    beat_t held;
    bit    holding;
    holding = 1'b0;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (holding) begin
          check(res_valid && {res_we, res_idx, res_data, res_sreg} == held, "R10",
                "held beat", {res_valid, 7'd0, res_data, res_sreg, 3'd0, res_idx}, {1'b1, 7'd0, held.data, held.sreg, 3'd0, held.idx});
          holding = 1'b0;
        end
        if (res_valid && !res_ready) begin
          held = {res_we, res_idx, res_data, res_sreg};
          holding = 1'b1;
        end else if (res_valid && res_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R10", "unexpected beat", 32'(res_data), 32'hFFFF_FFFF);
          end else begin
            beat_t e;
            string req;
            e = exp_q.pop_front();
            req = e.we ? "R3/R5" : "R9";
            check(res_we == e.we, req, "we", 32'(res_we), 32'(e.we));
            check(res_idx == e.idx, "R1", "idx", 32'(res_idx), 32'(e.idx));
            check(res_data == e.data, req, "data", 32'(res_data), 32'(e.data));
            check(res_sreg == e.sreg, "R4/R6/R7/R8", "sreg", 32'(res_sreg), 32'(e.sreg));
          end
        end
      end
    end
  end

  // Back-pressure generator
  initial begin
    int k;
    k = 0;
    forever begin
      @(negedge clk);
      k++;
      res_ready = bp_on ? (k % 3 == 0) : 1'b1;
    end
  end

  // Watchdog
  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    check(res_valid == 1'b0, "R11", "res_valid after reset", 32'(res_valid), 0);
    check(cmd_ready == 1'b1, "R11", "cmd_ready after reset", 32'(cmd_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: INC 0x7F -> 0x80, sreg 0x0C
    issue(16'h9453, 8'h7F, 8'h00);
    // R3 R4: INC 0xFF -> 0x00, Z only; C kept
    issue(16'h9453, 8'hFF, 8'h00);
    issue(16'h9453, 8'hFF, 8'h01);
    issue(16'h9503, 8'h00, 8'hE0);
    issue(16'h95F3, 8'h41, 8'h5F);
    // R2 R5 R6: ROR 0x11 carry clear -> 0x08 sreg 0x19; carry set -> 0x88
    issue(16'h9407, 8'h11, 8'h00);
    issue(16'h9407, 8'h11, 8'h01);
    issue(16'h9587, 8'h01, 8'hA0);
    issue(16'h94F7, 8'hFE, 8'h41);
    // R9: near-miss and foreign words
    issue(16'h9405, 8'h33, 8'hC3);
    issue(16'h9408, 8'h33, 8'h5A);
    issue(16'h9603, 8'h33, 8'h3C);
    issue(16'h0000, 8'h33, 8'hFF);
    idle();
    repeat (3) @(negedge clk);

    // R10: same patterns under back-pressure
    bp_on = 1'b1;
    for (int i = 0; i < 24; i++) begin
      logic [15:0] w;
      w = (i % 3 == 0) ? 16'h9403 : (i % 3 == 1) ? 16'h9407 : 16'h940B;
      w[8:4] = 5'(i);
      issue(w, 8'(i * 37 + 5), 8'(i * 11));
    end
    idle();
    bp_on = 1'b0;
    for (int t = 0; t < 100 && exp_q.size() != 0; t++) @(negedge clk);
    check(exp_q.size() == 0, "R10", "beats outstanding", 32'(exp_q.size()), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule